// File: doc/BRIEF.md
# Word-Spaced UART Peripheral

This block is a serial port that hangs off a simple register bus. Software reads and writes 32-bit registers placed four bytes apart. On the other side, one wire carries outgoing frames and one wire carries incoming frames. Each frame is 8 data bits, sent least significant bit first, with one start bit, one stop bit and no parity. Each direction has a single holding register in front of its shifter. There are no deeper queues. Both shifters run from a tick that repeats every `divisor` core clocks, and one serial bit lasts 16 ticks. Software sets the divisor as the core clock divided by sixteen times the bit rate, rounded to the nearest integer. The divisor has its own register and is never reached through a latch bit.

The transmit engine is a four-state machine. It moves from IDLE to START when the holding register has a character and the engine is free. It moves START to DATA after 16 ticks. It stays in DATA for 8 bits of 16 ticks each and then moves to STOP. After a further 16 ticks it returns from STOP to IDLE.

The receive engine has the same four states. It moves IDLE to START on a low level at the synchronised input. START returns to IDLE if the line is high at the 8th tick, and moves to DATA if the line is still low there. DATA samples one bit every 16 ticks and moves to STOP after 8 bits. STOP returns to IDLE at its 16th tick and hands over the character at that point. A single interrupt line summarises the receive and transmit conditions, and an identification register reports which condition is pending.

Top module: `uart_word_port`

## Requirements
- R1: After reset, txd is 1. The status word (offset 0x14) reads 0x20, the interrupt identification (offset 0x08) reads 0x01, the divisor (offset 0x24) reads 0, and irq is 0.
- R2: The divisor is read and written at offset 0x24 with no latch bit involved. Bits 15:8 of the control word at offset 0x10 hold the line control byte, and it reads back as written; code 3 means 8-bit characters. Offsets 0x1C and 0x20 read as 0.
- R3: One tick occurs every `divisor` clocks and one bit lasts 16 ticks. With a divisor of 0 there are no ticks, so a frame driven on rxd is not received.
- R4: A character written to offset 0x00 is sent on txd as one low start bit, then 8 data bits with the LSB first, then one high stop bit. Each bit lasts 16 ticks.
- R5: Status bit 5 is 1 while the transmit holding register can accept a character. A write to offset 0x00 while bit 5 is 0 is dropped and is never sent.
- R6: The receiver samples the start bit 8 ticks after the falling edge and discards the start if the line is high there. It then samples 8 data bits, LSB first, one every 16 ticks, and sets status bit 0 when the character is complete.
- R7: Reading offset 0x00 returns the held character and clears status bit 0.
- R8: If a character completes while status bit 0 is still 1, status bit 1 (overrun) is set and the held character is kept. Reading the status word clears bit 1.
- R9: Interrupt enable bit 0 enables the receive interrupt and bit 1 enables the transmit-empty interrupt. The identification register reads 0x04 when receive data is pending, otherwise 0x02 when transmit-empty is pending, otherwise 0x01. Receive has priority, and irq is 1 whenever the identification is not 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous reset, active low |
| bus_wr | input | 1 | write strobe, one clock per access |
| bus_rd | input | 1 | read strobe; reads of offsets 0x00 and 0x14 have side effects |
| bus_addr | input | 6 | byte address of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, decoded from bus_addr without a register stage |
| txd | output | 1 | serial output, high when idle |
| rxd | input | 1 | serial input |
| irq | output | 1 | interrupt request |

## Verification
The dropped transmit write is the hardest case to reach from the ports. The bench writes one character and waits for status bit 5 to return, which shows the character has moved into the shifter. It then writes a second character to fill the holding register and writes a third while bit 5 is clear. A reference queue of the characters that were accepted must then match every frame decoded from txd, so a third frame shows up as a failure. Overrun needs two complete frames with no read of the data register between them. The discarded start bit needs a low pulse that is shorter than the 8-tick midpoint.

// File: rtl/uart_word_pkg.sv
package uart_word_pkg;
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_state_t;

    localparam int CHAR_BITS     = 8;
    localparam int TICKS_PER_BIT = 16;
    localparam int MID_TICK      = TICKS_PER_BIT / 2 - 1;

    localparam logic [3:0] IX_DATA = 4'd0;
    localparam logic [3:0] IX_IEN  = 4'd1;
    localparam logic [3:0] IX_IID  = 4'd2;
    localparam logic [3:0] IX_FCTL = 4'd3;
    localparam logic [3:0] IX_LMC  = 4'd4;
    localparam logic [3:0] IX_STAT = 4'd5;
    localparam logic [3:0] IX_MSTA = 4'd6;
    localparam logic [3:0] IX_DIV  = 4'd9;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt >= divisor - DIV_W'(1));
    assign tick = (divisor != '0) && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt <= '0;
        else if (divisor == '0 || wrap)     cnt <= '0;
        else                                cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_word_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [CHAR_BITS-1:0] load_data,
    output logic                 busy,
    output logic                 txd
);
    localparam int BW = $clog2(CHAR_BITS);

    line_state_t          state;
    logic [3:0]           tcnt;
    logic [BW-1:0]        bitn;
    logic [CHAR_BITS-1:0] sh;
    logic                 bit_end;

    assign bit_end = (tcnt == 4'(TICKS_PER_BIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LN_IDLE;
            tcnt  <= '0;
            bitn  <= '0;
            sh    <= '0;
        end else if (state == LN_IDLE) begin
            if (load) begin
                state <= LN_START;
                tcnt  <= '0;
                sh    <= load_data;
            end
        end else if (tick) begin
            tcnt <= bit_end ? 4'd0 : tcnt + 4'd1;
            unique case (state)
                LN_START: if (bit_end) begin
                    state <= LN_DATA;
                    bitn  <= '0;
                end
                LN_DATA: if (bit_end) begin
                    sh <= sh >> 1;
                    if (bitn == BW'(CHAR_BITS - 1)) state <= LN_STOP;
                    else                            bitn  <= bitn + BW'(1);
                end
                LN_STOP: if (bit_end) state <= LN_IDLE;
                default: state <= LN_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = (state != LN_IDLE);
        unique case (state)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = sh[0];
            default:  txd = 1'b1;
        endcase
    end

    p_tick_gates_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LN_IDLE && !tick) |=> $stable(state));
    p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LN_DATA && tick && bit_end && bitn == BW'(CHAR_BITS - 1)) |=> txd);
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_word_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rxd,
    output logic                 done,
    output logic [CHAR_BITS-1:0] data
);
    localparam int BW = $clog2(CHAR_BITS);

    line_state_t          state;
    logic [1:0]           sync;
    logic                 rx_s;
    logic [3:0]           rcnt;
    logic [BW-1:0]        bitn;
    logic [CHAR_BITS-1:0] sh;
    logic                 bit_end;
    logic                 mid;

    assign rx_s    = sync[1];
    assign bit_end = (rcnt == 4'(TICKS_PER_BIT - 1));
    assign mid     = (rcnt == 4'(MID_TICK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LN_IDLE;
            rcnt  <= '0;
            bitn  <= '0;
            sh    <= '0;
        end else if (state == LN_IDLE) begin
            if (!rx_s) begin
                state <= LN_START;
                rcnt  <= '0;
            end
        end else if (tick) begin
            unique case (state)
                LN_START: begin
                    if (mid) begin
                        rcnt  <= '0;
                        bitn  <= '0;
                        state <= rx_s ? LN_IDLE : LN_DATA;
                    end else rcnt <= rcnt + 4'd1;
                end
                LN_DATA: begin
                    rcnt <= bit_end ? 4'd0 : rcnt + 4'd1;
                    if (bit_end) begin
                        sh <= {rx_s, sh[CHAR_BITS-1:1]};
                        if (bitn == BW'(CHAR_BITS - 1)) state <= LN_STOP;
                        else                            bitn  <= bitn + BW'(1);
                    end
                end
                LN_STOP: begin
                    rcnt <= bit_end ? 4'd0 : rcnt + 4'd1;
                    if (bit_end) state <= LN_IDLE;
                end
                default: state <= LN_IDLE;
            endcase
        end
    end

    always_comb begin
        done = (state == LN_STOP) && tick && bit_end;
        data = sh;
    end

    p_false_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LN_START && tick && mid && rx_s) |=> (state == LN_IDLE));
endmodule

// File: rtl/uart_word_port.sv
module uart_word_port
    import uart_word_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        txd,
    input  logic        rxd,
    output logic        irq
);
    logic [3:0]           idx;
    logic [DIV_W-1:0]     div_q;
    logic [7:0]           ien_q, fctl_q;
    logic [15:0]          lmc_q;
    logic [CHAR_BITS-1:0] thr, rbr, rx_data;
    logic                 thr_full, dr, oe;
    logic                 tick, tx_busy, tx_load, rx_done;
    logic                 rd_data, rd_stat, wr_data;
    logic [7:0]           iid, stat;
    logic                 unused_bits;

    assign idx         = bus_addr[5:2];
    assign rd_data     = bus_rd && idx == IX_DATA;
    assign rd_stat     = bus_rd && idx == IX_STAT;
    assign wr_data     = bus_wr && idx == IX_DATA;
    assign tx_load     = thr_full && !tx_busy;
    assign unused_bits = ^{bus_wdata[31:16], bus_addr[1:0]};

    uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(div_q), .tick(tick)
    );
    uart_tx_engine u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
        .load_data(thr), .busy(tx_busy), .txd(txd)
    );
    uart_rx_engine u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .done(rx_done), .data(rx_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0; ien_q <= '0; fctl_q <= '0; lmc_q <= '0;
            thr <= '0; thr_full <= 1'b0;
        end else begin
            if (bus_wr) begin
                unique case (idx)
                    IX_IEN:  ien_q  <= bus_wdata[7:0];
                    IX_FCTL: fctl_q <= bus_wdata[7:0];
                    IX_LMC:  lmc_q  <= bus_wdata[15:0];
                    IX_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
                    default: ;
                endcase
            end
            if (wr_data && !thr_full) begin
                thr      <= bus_wdata[7:0];
                thr_full <= 1'b1;
            end else if (tx_load) begin
                thr_full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr <= '0; dr <= 1'b0; oe <= 1'b0;
        end else begin
            if (rx_done && dr && !rd_data) begin
                oe <= 1'b1;
            end else if (rx_done) begin
                rbr <= rx_data;
                dr  <= 1'b1;
                if (rd_stat) oe <= 1'b0;
            end else begin
                if (rd_data) dr <= 1'b0;
                if (rd_stat) oe <= 1'b0;
            end
        end
    end

    always_comb begin
        stat = {2'b00, !thr_full, 3'b000, oe, dr};
        if (ien_q[0] && dr)             iid = 8'h04;
        else if (ien_q[1] && !thr_full) iid = 8'h02;
        else                            iid = 8'h01;
        irq = (iid != 8'h01);
        unique case (idx)
            IX_DATA: bus_rdata = {24'h0, rbr};
            IX_IEN:  bus_rdata = {24'h0, ien_q};
            IX_IID:  bus_rdata = {24'h0, iid};
            IX_FCTL: bus_rdata = {24'h0, fctl_q};
            IX_LMC:  bus_rdata = {16'h0, lmc_q};
            IX_STAT: bus_rdata = {24'h0, stat};
            IX_MSTA: bus_rdata = 32'h0;
            IX_DIV:  bus_rdata = 32'(div_q);
            default: bus_rdata = 32'h0;
        endcase
    end

    p_full_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && thr_full) |=> $stable(thr));
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_done) |=> !dr);
    p_old_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && dr && !rd_data) |=> (oe && $stable(rbr)));
    p_rx_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dr && ien_q[0]) |-> (irq && iid == 8'h04));
endmodule

// File: tb/tb_uart_word_port.sv
module tb_uart_word_port;
    localparam int CLK_PERIOD = 10;
    localparam int DIVV       = 2;
    localparam int BITCLK     = 16 * DIVV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd, irq;
    logic        rxd = 1'b1;

    int total = 0, bad = 0, tx_frames = 0;
    logic [7:0] exp_q[$];

    uart_word_port dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk); rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    // Serial decoder of txd, compared against the queue of accepted characters (R4)
    initial begin
        logic [7:0] got;
        wait (rst_n);
        forever begin
            @(negedge txd);
            repeat (BITCLK/2) @(posedge clk);
            #1 check(txd == 1'b0, "R4 start bit", {31'h0, txd}, 32'h0);
            for (int i = 0; i < 8; i++) begin
                repeat (BITCLK) @(posedge clk);
                #1 got[i] = txd;
            end
            repeat (BITCLK) @(posedge clk);
            #1 check(txd == 1'b1, "R4 stop bit", {31'h0, txd}, 32'h1);
            tx_frames++;
            if (exp_q.size() == 0) check(1'b0, "R5 unexpected frame", {24'h0, got}, 32'h0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(got == e, "R4 frame data", {24'h0, got}, {24'h0, e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle", {31'h0, txd}, 32'h1);
        check(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
        rd_chk(6'h14, 32'h20, "R1 status");
        rd_chk(6'h08, 32'h01, "R1 ident");
        rd_chk(6'h24, 32'h00, "R1 divisor");

        // R3: divisor 0 gives no ticks, nothing received
        send_rx(8'h55);
        repeat (20) @(negedge clk);
        rd_chk(6'h14, 32'h20, "R3 no rx at div 0");

        // R2 register placement
        wr(6'h24, DIVV);
        rd_chk(6'h24, DIVV, "R2 divisor");
        wr(6'h10, 32'h0000_0300);
        rd(6'h10, v);
        check(v[15:8] == 8'h03, "R2 line ctrl byte", {24'h0, v[15:8]}, 32'h3);
        rd_chk(6'h1C, 32'h0, "R2 reserved 1C");
        rd_chk(6'h20, 32'h0, "R2 reserved 20");
        repeat (60) @(negedge clk);

        // R4/R5 transmit with a dropped write
        wr(6'h00, 32'hC1); exp_q.push_back(8'hC1);
        do rd(6'h14, v); while (!v[5]);
        wr(6'h00, 32'h5E); exp_q.push_back(8'h5E);
        rd(6'h14, v);
        check(v[5] == 1'b0, "R5 holding full", {31'h0, v[5]}, 32'h0);
        wr(6'h00, 32'hFF);
        repeat (12 * 10 * BITCLK / 4) @(negedge clk);
        check(tx_frames == 2, "R5 dropped write not sent", tx_frames, 2);
        check(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
        check(txd == 1'b1, "R4 line idle", {31'h0, txd}, 32'h1);

        // R6/R7 receive
        send_rx(8'h4B);
        rd_chk(6'h14, 32'h21, "R6 data ready");
        rd_chk(6'h00, 32'h4B, "R6 received char");
        rd_chk(6'h14, 32'h20, "R7 read clears ready");

        // R6 short low pulse rejected
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BITCLK) @(negedge clk);
        rd_chk(6'h14, 32'h20, "R6 false start rejected");

        // R8 overrun
        send_rx(8'h12);
        send_rx(8'h87);
        rd_chk(6'h14, 32'h23, "R8 overrun set");
        rd_chk(6'h14, 32'h21, "R8 status read clears overrun");
        rd_chk(6'h00, 32'h12, "R8 old char kept");
        rd_chk(6'h14, 32'h20, "R8 clean");

        // R9 interrupts
        wr(6'h04, 32'h03);
        send_rx(8'h99);
        rd_chk(6'h08, 32'h04, "R9 rx priority");
        check(irq == 1'b1, "R9 irq rx", {31'h0, irq}, 32'h1);
        rd_chk(6'h00, 32'h99, "R9 rx char");
        rd_chk(6'h08, 32'h02, "R9 tx empty");
        check(irq == 1'b1, "R9 irq tx", {31'h0, irq}, 32'h1);
        wr(6'h04, 32'h00);
        rd_chk(6'h08, 32'h01, "R9 none pending");
        check(irq == 1'b0, "R9 irq off", {31'h0, irq}, 32'h0);
        wr(6'h04, 32'h01);
        rd_chk(6'h08, 32'h01, "R9 rx enable only, no data");
        wr(6'h04, 32'h00);

        summary();
    end
endmodule